// File: doc/BRIEF.md
# Non-Overlapping Pulse Pattern Generator

This block drives an 8-bit pattern port from a staged next-data register, with updates timed by an internal up-counter. Two compare values are programmed: a period value, which clears the counter when reached and so fixes the output update rate, and a margin value, which marks a point inside each period. The port is treated as two 4-bit groups. Each group has its own update enable and its own non-overlap mode bit. A per-bit output mask further selects which bits may change.

In normal mode, an enabled group copies its staged bits to the port at the period match. In non-overlap mode, the update is split in two. Bits that fall take their new value at the period match. Bits that rise wait until the margin match. This leaves a dead time of margin-plus-one counter ticks between one phase switching off and its complementary phase switching on.

A margin match sets a sticky flag, which is cleared by writing one. When requests are enabled, the match also produces a one-cycle request pulse. Software or a transfer engine uses that pulse to stage the next pattern. Staging 0x95, 0x65, 0x59, 0x56 in turn, with both groups in non-overlap mode, gives four-phase complementary output.

Top module: `nov_pulse_gen`

## Requirements
- R1: After reset the port is 0x00, the margin flag is 0, the request output is 0 and the counter is 0.
- R2: While `run` is 1, the counter counts up by one per cycle. When it equals the period register (write address 0), it returns to 0 on the next cycle, so a period value P gives one period match every P+1 cycles. In normal mode (config bit 2 for the low group, bit 3 for the high group, cleared), every updatable bit of the group takes its staged value in the cycle that follows the period match.
- R3: In non-overlap mode, a bit that is 1 on the port and 0 in the staged data (write address 2, data bits 7:0) changes to 0 in the cycle after the period match, and at no other time.
- R4: In non-overlap mode, a bit that is 0 on the port and 1 in the staged data changes to 1 in the cycle after the margin match (counter equal to the margin register, write address 1), and never at a period match.
- R5: Non-overlap mode is chosen per group: config bit 2 sets it for port bits 3:0 and config bit 3 sets it for port bits 7:4. The two groups may run in different modes at the same time.
- R6: A port bit changes only when both of these are 1: its output-enable bit (config bits 15:8, one per port bit) and its group's update enable (config bit 0 for bits 3:0, bit 1 for bits 7:4). Otherwise the bit keeps its value.
- R7: If the staged data is not rewritten, later period matches apply the same value again, so the port does not change. Outside the cycles that follow a period match or a margin match, the port never changes.
- R8: A margin register value greater than or equal to the period register value produces no margin match. No bit rises in non-overlap mode, and the flag and the request stay 0.
- R9: The margin flag is set in the cycle after a margin match. It stays set until a write to address 4 with data bit 0 equal to 1. If a margin match and a clear happen in the same cycle, the set wins.
- R10: When the request enable (config bit 4) is 1, `marginReq` is 1 for exactly the one cycle after each margin match. When the request enable is 0, `marginReq` stays 0.
- R11: While `run` is 0, the counter is held at 0 and no match occurs. After `run` returns to 1, counting starts again from 0.
- R12: With both groups enabled in non-overlap mode, staging 0x95, 0x65, 0x59, 0x56 once per period gives a port that holds the AND of the old and new patterns from the period match until the margin match, and then holds the new pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address: 0 period, 1 margin, 2 staged data, 3 config, 4 flag clear |
| wrData | input | 16 | Write data |
| run | input | 1 | Counter run control; the counter is held at 0 while this is low |
| patOut | output | 8 | Pattern output port |
| marginFlag | output | 1 | Sticky margin-match flag |
| marginReq | output | 1 | One-cycle pulse after a margin match when requests are enabled |

## Verification
A period match or a margin match is decoded from the counter in the same cycle. The port, flag and request registers capture the result at the next clock edge, so every result shows up one cycle after the counter reaches the compare value. A register write likewise takes effect from the edge that samples it. The bench drives inputs at the falling edge. Its reference model is stepped once per rising edge using the register contents from before that edge, and it compares all outputs at the following falling edge, one cycle after each stimulus. Directed sections cover each mode and corner case, and a seeded random phase mixes periods, margins and configurations.

// File: rtl/nov_pkg.sv
package nov_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MARGIN = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_NEXT   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CFG    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CLR    = 3'd4;

  typedef struct packed {
    logic periodHit;
    logic marginHit;
  } strobe_t;
endpackage

// File: rtl/nov_ctrl.sv
module nov_ctrl
  import nov_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int GRP_W  = 4,
  parameter int WR_W   = 16,
  localparam int NGRP  = DATA_W / GRP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WR_W-1:0]   wrData,
  input  logic              run,
  output strobe_t           strb,
  output logic [NGRP-1:0]   grpEn,
  output logic [NGRP-1:0]   novEn,
  output logic [DATA_W-1:0] oeMask,
  output logic              marginFlag,
  output logic              marginReq
);
  localparam int REQ_BIT = 2 * NGRP;
  localparam int OE_LSB  = 8;

  logic [CNT_W-1:0] cnt, periodReg, marginReg;
  logic             reqEn;

  always_comb begin
    strb.periodHit = run && (cnt == periodReg);
    strb.marginHit = run && (cnt == marginReg) && (marginReg < periodReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (!run || strb.periodHit) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '0;
      marginReg <= '0;
      grpEn     <= '0;
      novEn     <= '0;
      reqEn     <= 1'b0;
      oeMask    <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_PERIOD: periodReg <= wrData[CNT_W-1:0];
        ADDR_MARGIN: marginReg <= wrData[CNT_W-1:0];
        ADDR_CFG: begin
          grpEn  <= wrData[NGRP-1:0];
          novEn  <= wrData[2*NGRP-1:NGRP];
          reqEn  <= wrData[REQ_BIT];
          oeMask <= wrData[OE_LSB+DATA_W-1:OE_LSB];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      marginFlag <= 1'b0;
      marginReq  <= 1'b0;
    end else begin
      marginReq <= strb.marginHit && reqEn;
      if (strb.marginHit) marginFlag <= 1'b1;
      else if (wrEn && wrAddr == ADDR_CLR && wrData[0]) marginFlag <= 1'b0;
    end
  end

  assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (run && cnt == periodReg) |=> (cnt == '0));
  assert_stop_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (cnt == '0));
  assert_no_margin_R8: assert property (@(posedge clk) disable iff (!rstN)
    (marginReg >= periodReg && $stable(marginReg) && $stable(periodReg)) |=> !marginReq);
  assert_req_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    marginReq |-> marginFlag);
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (marginFlag && !(wrEn && wrAddr == ADDR_CLR)) |=> marginFlag);
endmodule

// File: rtl/nov_datapath.sv
module nov_datapath
  import nov_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GRP_W  = 4,
  parameter int WR_W   = 16,
  localparam int NGRP  = DATA_W / GRP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WR_W-1:0]   wrData,
  input  logic [NGRP-1:0]   grpEn,
  input  logic [NGRP-1:0]   novEn,
  input  logic [DATA_W-1:0] oeMask,
  output logic [DATA_W-1:0] patOut
);
  logic [DATA_W-1:0] nextData, novMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nextData <= '0;
    else if (wrEn && wrAddr == ADDR_NEXT) nextData <= wrData[DATA_W-1:0];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : gBit
    localparam int G = i / GRP_W;
    logic bitQ, canUpd;
    assign canUpd     = oeMask[i] & grpEn[G];
    assign novMask[i] = novEn[G];
    assign patOut[i]  = bitQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bitQ <= 1'b0;
      else if (canUpd) begin
        if (strb.periodHit) begin
          if (!novEn[G]) bitQ <= nextData[i];
          else if (bitQ && !nextData[i]) bitQ <= 1'b0;
        end else if (strb.marginHit && novEn[G] && !bitQ && nextData[i]) begin
          bitQ <= 1'b1;
        end
      end
    end
  end

  assert_nov_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.marginHit |=> ((patOut & ~$past(patOut) & $past(novMask)) == '0));
  assert_nov_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.periodHit |=> ((~patOut & $past(patOut) & $past(novMask)) == '0));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.periodHit && !strb.marginHit) |=> $stable(patOut));
  assert_masked_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (oeMask == '0) |=> $stable(patOut));
endmodule

// File: rtl/nov_pulse_gen.sv
module nov_pulse_gen
  import nov_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int GRP_W  = 4,
  parameter int WR_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [WR_W-1:0]   wrData,
  input  logic              run,
  output logic [DATA_W-1:0] patOut,
  output logic              marginFlag,
  output logic              marginReq
);
  localparam int NGRP = DATA_W / GRP_W;

  strobe_t           strb;
  logic [NGRP-1:0]   grpEn, novEn;
  logic [DATA_W-1:0] oeMask;

  nov_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W), .GRP_W(GRP_W), .WR_W(WR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .run(run), .strb(strb), .grpEn(grpEn), .novEn(novEn), .oeMask(oeMask),
    .marginFlag(marginFlag), .marginReq(marginReq)
  );

  nov_datapath #(.DATA_W(DATA_W), .GRP_W(GRP_W), .WR_W(WR_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .grpEn(grpEn), .novEn(novEn), .oeMask(oeMask),
    .patOut(patOut)
  );
endmodule

// File: tb/tb_nov_pulse_gen.sv
module tb_nov_pulse_gen;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        run = 1'b0;
  logic [7:0]  patOut;
  logic        marginFlag, marginReq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // reference model state
  int unsigned mCnt, mPer, mMar;
  logic [7:0] mOut, mNext, mOe;
  logic [1:0] mGrp, mNov;
  logic mReqEn, mFlag, mReq;

  nov_pulse_gen dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++; checks++;
        $display("FAIL R11 watchdog: cycles=%0d expected<150000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  function automatic logic [7:0] nextOut(logic [7:0] cur, logic ph, logic mh);
    logic [7:0] r = cur;
    for (int i = 0; i < 8; i++) begin
      int g = i / 4;
      if (mOe[i] && mGrp[g]) begin
        if (ph) begin
          if (!mNov[g]) r[i] = mNext[i];
          else if (cur[i] && !mNext[i]) r[i] = 1'b0;
        end else if (mh && mNov[g] && !cur[i] && mNext[i]) r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic tick(string tag);
    logic ph, mh;
    ph = run && (mCnt == mPer);
    mh = run && (mCnt == mMar) && (mMar < mPer);
    @(posedge clk);
    mOut = nextOut(mOut, ph, mh);
    mReq = mh && mReqEn;
    if (mh) mFlag = 1'b1;
    else if (wrEn && wrAddr == 3'd4 && wrData[0]) mFlag = 1'b0;
    mCnt = (!run || ph) ? 0 : (mCnt + 1) & 16'hFFFF;
    if (wrEn) begin
      case (wrAddr)
        3'd0: mPer = wrData;
        3'd1: mMar = wrData;
        3'd2: mNext = wrData[7:0];
        3'd3: begin
          mGrp = wrData[1:0]; mNov = wrData[3:2];
          mReqEn = wrData[4]; mOe = wrData[15:8];
        end
        default: ;
      endcase
    end
    @(negedge clk);
    check({tag, " port"}, 32'(patOut), 32'(mOut));
    check({tag, " flag"}, 32'(marginFlag), 32'(mFlag));
    check({tag, " req"}, 32'(marginReq), 32'(mReq));
    wrEn = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d, string tag);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick(tag);
  endtask

  task automatic ticks(int n, string tag);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  logic [7:0] seq [4] = '{8'h95, 8'h65, 8'h59, 8'h56};

  initial begin
    void'($urandom(32'd1234));
    mCnt = 0; mPer = 0; mMar = 0; mOut = 0; mNext = 0; mOe = 0;
    mGrp = 0; mNov = 0; mReqEn = 0; mFlag = 0; mReq = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 port", 32'(patOut), 32'h0);
    check("R1 flag", 32'(marginFlag), 32'h0);
    check("R1 req", 32'(marginReq), 32'h0);

    // R2 normal mode, period 9, margin 4
    wr(3'd0, 16'd9, "R2");
    wr(3'd1, 16'd4, "R2");
    wr(3'd2, 16'h3C, "R2");
    wr(3'd3, 16'hFF13, "R10");
    run = 1'b1;
    ticks(10, "R2");
    check("R2 applied", 32'(patOut), 32'h3C);
    wr(3'd4, 16'd1, "R9");
    ticks(30, "R7");
    check("R7 unchanged", 32'(patOut), 32'h3C);

    // R12 four-phase non-overlap, both groups
    wr(3'd3, 16'hFF1F, "R12");
    for (int r = 0; r < 3; r++)
      for (int s = 0; s < 4; s++) begin
        wr(3'd2, {8'h0, seq[s]}, "R12");
        while (!mFlag) tick("R12 R3 R4");
        wr(3'd4, 16'd1, "R9");
        ticks(3, "R12");
      end

    // R5 mixed modes: high nibble non-overlap only, margin 6
    wr(3'd1, 16'd6, "R5");
    wr(3'd3, 16'hFF1B, "R5");
    for (int s = 0; s < 4; s++) begin
      wr(3'd2, {8'h0, seq[s]}, "R5");
      ticks(10, "R5 R4");
    end

    // R6 masks: only low group updates, oe only bits 1:0
    wr(3'd3, 16'h0301, "R6");
    wr(3'd2, 16'hAA, "R6");
    ticks(12, "R6");
    wr(3'd2, 16'h55, "R6");
    ticks(12, "R6");

    // R10 requests off
    wr(3'd3, 16'hFF0F, "R10");
    ticks(12, "R10");
    check("R10 req off", 32'(marginReq), 32'h0);

    // R9 clear while flag already set
    wr(3'd4, 16'd1, "R9");
    ticks(4, "R9");
    wr(3'd4, 16'd0, "R9 no clear");

    // R8 margin >= period: no rising edge, no flag
    wr(3'd4, 16'd1, "R8");
    wr(3'd3, 16'hFF1F, "R8");
    wr(3'd1, 16'd12, "R8");
    wr(3'd2, 16'hFF, "R8");
    ticks(25, "R8");
    check("R8 flag", 32'(marginFlag), 32'h0);
    wr(3'd1, 16'd9, "R8 equal");
    ticks(25, "R8");
    check("R8 flag eq", 32'(marginFlag), 32'h0);

    // R11 stop and restart
    wr(3'd1, 16'd3, "R11");
    ticks(5, "R11");
    run = 1'b0;
    ticks(7, "R11");
    run = 1'b1;
    ticks(25, "R11");

    // random mix
    for (int r = 0; r < 60; r++) begin
      wr(3'd0, 16'($urandom_range(1, 12)), "R2 rnd");
      wr(3'd1, 16'($urandom_range(0, 14)), "R4 rnd");
      wr(3'd3, {8'($urandom), 3'b0, 5'($urandom)}, "R6 rnd");
      wr(3'd2, 16'($urandom_range(0, 255)), "R3 rnd");
      if ($urandom_range(0, 3) == 0) run = 1'b0;
      ticks($urandom_range(5, 30), "R7 rnd");
      run = 1'b1;
      if ($urandom_range(0, 1) == 1) wr(3'd4, 16'd1, "R9 rnd");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule